// File: doc/BRIEF.md
# External Bus Loan Controller

This block decides who drives the external memory pins: the on-chip memory controller or an external bus master. The external master raises a request. The block synchronizes the request into the local clock domain. It then waits until the internal controller reports that its current access has finished, and only then returns an acknowledge. An access that is already under way is never cut short, and a request withdrawn before the grant produces no grant.

At the acknowledge, the synchronous DRAM chip select is forced high and stays actively driven for the whole loan. This keeps a write that was interrupted from turning into a stray write while the control pins float. In the same cycle the control-pin output enables turn off. The address and data enables follow one or two memory clocks later, selected by a configuration input.

While the bus is lent out, internal refresh is withheld. Any refresh request that arrives in that time is remembered. It is issued as the very first internal operation once the bus comes back. When the external master drops its request, the block first takes the pins back. One clock later it clears the acknowledge.

Top module: `busloan_ctrl`

## Requirements
- R1: After reset the acknowledge is low, both output enables are high, `mc_hold` is low, and the chip select output follows `mc_sdcs_n`.
- R2: A request is seen through a two-stage synchronizer. With `mc_cycle_done` held high, the acknowledge goes high on the fourth rising edge after the request is raised, and not before. A request that drops before the grant leaves the acknowledge low.
- R3: The acknowledge rises only after a cycle in which `mc_cycle_done` was high. While it is low, the block waits with the acknowledge low.
- R4: While the acknowledge is high, `sdcs_n_out` is 1 whatever `mc_sdcs_n` is.
- R5: In the cycle the acknowledge rises, `ctrl_oe` is 0. It stays 0 until the return step.
- R6: `addr_data_oe` stays 1 for one cycle after the acknowledge rises when `cfg_two_clk`=0, and for two cycles when `cfg_two_clk`=1. After that it is 0.
- R7: On the third rising edge after the request drops, both output enables return to 1 while the acknowledge is still 1. The acknowledge falls on the next edge.
- R8: While the bus is not owned internally, `refresh_go` stays 0 regardless of `refresh_req`.
- R9: A refresh requested during a loan makes `refresh_go` 1, with `mc_hold` 1, in the first cycle after the acknowledge falls. Both are 0 in the cycle after that. With no loan, `refresh_go` follows `refresh_req` in the same cycle.
- R10: `mc_hold` is 1 from the edge after the synchronized request is seen until the bus is back with no refresh pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_req | input | 1 | Bus request from external master (asynchronous) |
| mc_cycle_done | input | 1 | Internal controller has no access in flight |
| mc_sdcs_n | input | 1 | Sync DRAM chip select from internal controller |
| cfg_two_clk | input | 1 | 0: release address/data 1 clock after acknowledge; 1: after 2 |
| refresh_req | input | 1 | Refresh request from the refresh timer |
| ext_ack | output | 1 | Bus acknowledge to external master |
| sdcs_n_out | output | 1 | Sync DRAM chip select to pad, always driven |
| ctrl_oe | output | 1 | Output enable for control pins (OE, byte/DRAM write enables, ROM selects, CAS, RAS) |
| addr_data_oe | output | 1 | Output enable for address and data pins |
| refresh_go | output | 1 | Refresh issue strobe to the internal controller |
| mc_hold | output | 1 | Tells the internal controller to start no new access |

## Verification
The grant path is driven four ways. A request with the controller idle and the short delay measures the synchronizer latency and the one-cycle address release. The same request with the long delay separates the two release settings. A request held while the controller stays busy shows that the grant waits for cycle completion. A request withdrawn during that wait shows that no late grant is issued. Return is checked edge by edge to separate pin reclaim from acknowledge release. A refresh pulse during a loan, contrasted with one during internal ownership, distinguishes suppression and deferred issue from passthrough.

// File: rtl/busloan_pkg.sv
package busloan_pkg;

    typedef enum logic [2:0] {
        OWNED_INTERNAL = 3'd0,
        WAIT_CYCLE_END = 3'd1,
        GRANT_GUARD    = 3'd2,
        GRANTED        = 3'd3,
        RETURN         = 3'd4
    } loan_state_e;

    typedef struct packed {
        logic ack;
        logic cs_force;
        logic ctrl_oe;
        logic addr_oe;
        logic internal;
    } pin_ctl_t;

    function automatic pin_ctl_t decode_pins(loan_state_e s);
        pin_ctl_t p;
        p.ack      = (s == GRANT_GUARD) || (s == GRANTED) || (s == RETURN);
        p.cs_force = p.ack;
        p.ctrl_oe  = !((s == GRANT_GUARD) || (s == GRANTED));
        p.addr_oe  = (s != GRANTED);
        p.internal = (s == OWNED_INTERNAL);
        return p;
    endfunction

endpackage

// File: rtl/busloan_sync.sv
module busloan_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/busloan_fsm.sv
module busloan_fsm
    import busloan_pkg::*;
#(
    parameter int SHORT_DLY = 1,
    parameter int LONG_DLY  = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_sync,
    input  logic        cycle_done,
    input  logic        two_clk,
    output loan_state_e state
);
    localparam int DLY_W = $clog2(LONG_DLY + 1);
    localparam logic [DLY_W-1:0] SHORT_LOAD = DLY_W'(SHORT_DLY - 1);
    localparam logic [DLY_W-1:0] LONG_LOAD  = DLY_W'(LONG_DLY - 1);

    loan_state_e      nxt;
    logic [DLY_W-1:0] cnt;

    always_comb begin
        nxt = state;
        unique case (state)
            OWNED_INTERNAL: if (req_sync) nxt = WAIT_CYCLE_END;
            WAIT_CYCLE_END: begin
                if (!req_sync)       nxt = OWNED_INTERNAL;
                else if (cycle_done) nxt = GRANT_GUARD;
            end
            GRANT_GUARD: begin
                if (!req_sync)     nxt = RETURN;
                else if (cnt == '0) nxt = GRANTED;
            end
            GRANTED: if (!req_sync) nxt = RETURN;
            RETURN:  nxt = OWNED_INTERNAL;
            default: nxt = OWNED_INTERNAL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= OWNED_INTERNAL;
            cnt   <= '0;
        end else begin
            state <= nxt;
            if (state == WAIT_CYCLE_END)
                cnt <= two_clk ? LONG_LOAD : SHORT_LOAD;
            else if (state == GRANT_GUARD && cnt != '0)
                cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/busloan_refresh.sv
module busloan_refresh (
    input  logic clk,
    input  logic rst,
    input  logic internal,
    input  logic refresh_req,
    output logic refresh_go,
    output logic pending
);
    always_ff @(posedge clk) begin
        if (rst)                          pending <= 1'b0;
        else if (!internal && refresh_req) pending <= 1'b1;
        else if (internal)                pending <= 1'b0;
    end

    assign refresh_go = internal && (refresh_req || pending);
endmodule

// File: rtl/busloan_ctrl.sv
module busloan_ctrl
    import busloan_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int SHORT_DLY   = 1,
    parameter int LONG_DLY    = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ext_req,
    input  logic mc_cycle_done,
    input  logic mc_sdcs_n,
    input  logic cfg_two_clk,
    input  logic refresh_req,
    output logic ext_ack,
    output logic sdcs_n_out,
    output logic ctrl_oe,
    output logic addr_data_oe,
    output logic refresh_go,
    output logic mc_hold
);
    logic        req_sync;
    logic        pend;
    loan_state_e state;
    pin_ctl_t    pins;

    busloan_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(ext_req), .q(req_sync)
    );

    busloan_fsm #(.SHORT_DLY(SHORT_DLY), .LONG_DLY(LONG_DLY)) u_fsm (
        .clk(clk), .rst(rst), .req_sync(req_sync),
        .cycle_done(mc_cycle_done), .two_clk(cfg_two_clk), .state(state)
    );

    assign pins = decode_pins(state);

    busloan_refresh u_ref (
        .clk(clk), .rst(rst), .internal(pins.internal),
        .refresh_req(refresh_req), .refresh_go(refresh_go), .pending(pend)
    );

    assign ext_ack      = pins.ack;
    assign sdcs_n_out   = pins.cs_force ? 1'b1 : mc_sdcs_n;
    assign ctrl_oe      = pins.ctrl_oe;
    assign addr_data_oe = pins.addr_oe;
    assign mc_hold      = !pins.internal || pend;
endmodule

// File: rtl/busloan_ctrl_chk.sv
module busloan_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic req_sync,
    input logic mc_cycle_done,
    input logic ext_ack,
    input logic sdcs_n_out,
    input logic ctrl_oe,
    input logic addr_data_oe,
    input logic refresh_go,
    input logic mc_hold
);
    p_ack_needs_req_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(ext_ack) |-> $past(req_sync));
    p_grant_after_done_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(ext_ack) |-> $past(mc_cycle_done));
    p_cs_high_r4: assert property (@(posedge clk) disable iff (rst)
        ext_ack |-> sdcs_n_out);
    p_ctrl_off_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(ext_ack) |-> !ctrl_oe);
    p_addr_held_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(ext_ack) |-> addr_data_oe);
    p_pins_back_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(ext_ack) |-> $past(ctrl_oe && addr_data_oe));
    p_no_refresh_r8: assert property (@(posedge clk) disable iff (rst)
        ext_ack |-> !refresh_go);
    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        ext_ack |-> mc_hold);
endmodule

bind busloan_ctrl busloan_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .req_sync(req_sync), .mc_cycle_done(mc_cycle_done),
    .ext_ack(ext_ack), .sdcs_n_out(sdcs_n_out), .ctrl_oe(ctrl_oe),
    .addr_data_oe(addr_data_oe), .refresh_go(refresh_go), .mc_hold(mc_hold)
);

// File: tb/busloan_ctrl_tb_top.sv
module busloan_ctrl_tb_top;
    logic clk = 1'b0;
    logic rst, ext_req, mc_cycle_done, mc_sdcs_n, cfg_two_clk, refresh_req;
    logic ext_ack, sdcs_n_out, ctrl_oe, addr_data_oe, refresh_go, mc_hold;
    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    busloan_ctrl dut_i (
        .clk(clk), .rst(rst), .ext_req(ext_req), .mc_cycle_done(mc_cycle_done),
        .mc_sdcs_n(mc_sdcs_n), .cfg_two_clk(cfg_two_clk), .refresh_req(refresh_req),
        .ext_ack(ext_ack), .sdcs_n_out(sdcs_n_out), .ctrl_oe(ctrl_oe),
        .addr_data_oe(addr_data_oe), .refresh_go(refresh_go), .mc_hold(mc_hold)
    );

    task automatic step(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; ext_req = 1'b0; mc_cycle_done = 1'b1; mc_sdcs_n = 1'b0;
        cfg_two_clk = 1'b0; refresh_req = 1'b0;
        step(2);
        rst = 1'b0;
        step(1);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1", "ack", ext_ack, 1'b0);
        chk("R1", "ctrl_oe", ctrl_oe, 1'b1);
        chk("R1", "addr_data_oe", addr_data_oe, 1'b1);
        chk("R1", "mc_hold", mc_hold, 1'b0);
        chk("R1", "cs follows low", sdcs_n_out, 1'b0);
        mc_sdcs_n = 1'b1; #1;
        chk("R1", "cs follows high", sdcs_n_out, 1'b1);
        mc_sdcs_n = 1'b0;
        refresh_req = 1'b1; #1;
        chk("R9", "refresh passthrough", refresh_go, 1'b1);
        refresh_req = 1'b0; #1;
        chk("R9", "refresh passthrough off", refresh_go, 1'b0);
    endtask

    // grant with controller idle; release delay chosen by two
    task automatic t_grant(logic two);
        do_reset();
        cfg_two_clk = two;
        ext_req = 1'b1;
        step(2);
        chk("R10", "hold before sync seen", mc_hold, 1'b0);
        step(1);
        chk("R2", "ack not yet", ext_ack, 1'b0);
        chk("R10", "hold while waiting", mc_hold, 1'b1);
        step(1);
        chk("R2", "ack on 4th edge", ext_ack, 1'b1);
        chk("R4", "cs forced high", sdcs_n_out, 1'b1);
        chk("R5", "ctrl released", ctrl_oe, 1'b0);
        chk("R6", "addr held at ack", addr_data_oe, 1'b1);
        if (two) begin
            step(1);
            chk("R6", "addr held 2nd cycle", addr_data_oe, 1'b1);
        end
        step(1);
        chk("R6", "addr released", addr_data_oe, 1'b0);
        chk("R5", "ctrl still released", ctrl_oe, 1'b0);
        chk("R4", "cs still high", sdcs_n_out, 1'b1);
    endtask

    task automatic t_return();
        ext_req = 1'b0;
        step(2);
        chk("R7", "ack kept", ext_ack, 1'b1);
        chk("R7", "addr still off", addr_data_oe, 1'b0);
        step(1);
        chk("R7", "ctrl back", ctrl_oe, 1'b1);
        chk("R7", "addr back", addr_data_oe, 1'b1);
        chk("R7", "ack during return", ext_ack, 1'b1);
        chk("R4", "cs high during return", sdcs_n_out, 1'b1);
        step(1);
        chk("R7", "ack dropped", ext_ack, 1'b0);
        chk("R1", "cs follows again", sdcs_n_out, 1'b0);
        chk("R10", "hold cleared", mc_hold, 1'b0);
    endtask

    task automatic t_busy_wait();
        do_reset();
        mc_cycle_done = 1'b0;
        ext_req = 1'b1;
        step(8);
        chk("R3", "no ack while busy", ext_ack, 1'b0);
        chk("R3", "ctrl kept while busy", ctrl_oe, 1'b1);
        chk("R10", "hold while busy", mc_hold, 1'b1);
        mc_cycle_done = 1'b1;
        step(1);
        chk("R3", "ack after done", ext_ack, 1'b1);
        mc_cycle_done = 1'b0;
        t_return();
    endtask

    task automatic t_abort();
        logic seen;
        do_reset();
        mc_cycle_done = 1'b0;
        ext_req = 1'b1;
        step(5);
        ext_req = 1'b0;
        step(2);
        mc_cycle_done = 1'b1;
        seen = 1'b0;
        for (int i = 0; i < 6; i++) begin
            step(1);
            if (ext_ack) seen = 1'b1;
        end
        chk("R2", "no grant after withdraw", seen, 1'b0);
        chk("R10", "hold released", mc_hold, 1'b0);
    endtask

    task automatic t_refresh_loan();
        logic any;
        t_grant(1'b0);
        any = 1'b0;
        refresh_req = 1'b1; #1;
        if (refresh_go) any = 1'b1;
        step(1);
        refresh_req = 1'b0;
        if (refresh_go) any = 1'b1;
        ext_req = 1'b0;
        for (int i = 0; i < 3; i++) begin
            step(1);
            if (refresh_go) any = 1'b1;
        end
        chk("R8", "no refresh during loan", any, 1'b0);
        chk("R7", "ack still high", ext_ack, 1'b1);
        step(1);
        chk("R9", "ack low", ext_ack, 1'b0);
        chk("R9", "deferred refresh", refresh_go, 1'b1);
        chk("R9", "hold with refresh", mc_hold, 1'b1);
        step(1);
        chk("R9", "refresh one cycle", refresh_go, 1'b0);
        chk("R9", "hold cleared", mc_hold, 1'b0);
    endtask

    initial begin
        t_reset();
        t_grant(1'b0);
        t_return();
        t_grant(1'b1);
        mc_sdcs_n = 1'b1; #1;
        chk("R4", "cs high with high input", sdcs_n_out, 1'b1);
        mc_sdcs_n = 1'b0;
        t_return();
        t_busy_wait();
        t_abort();
        t_refresh_loan();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected under 20000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule